// File: doc/BRIEF.md
# SIMD Multi-Cycle Instruction Sequencer

This block is the control unit of a small non-pipelined SIMD processor. It fetches one 32-bit instruction word at a time from a memory addressed by 10-bit word addresses. It then resolves the second operand according to the addressing mode and broadcasts the decoded operation to a row of identical processing lanes. The sequencer owns the program counter, the instruction register, the operand register and the phase state machine. The lanes do the arithmetic themselves.

Each instruction passes through a fixed set of phases. Fetch takes two cycles. The operand phase takes three cycles: capture the word, decode the addressing mode, then decode the operation. A memory operand adds one wait cycle. Execution takes one cycle. After execution there is an optional write-back cycle, in which the lanes copy their result register into a general register. Buffer stores take four cycles. Only one instruction is ever in flight.

Top module: `simd_seq`

## Requirements
- R1: An instruction word is split into an operation field in bits [31:22] and an operand field in bits [21:0]. These fields are driven unchanged on `pe_op` and `pe_opnd`.
- R2: A fetch drives `mem_rd` with `mem_addr` equal to the program counter in its first cycle and waits one more cycle. The memory returns the word in the cycle after the request. The program counter then advances by one and wraps from 1023 to 0.
- R3: For a non-control instruction with an immediate operand, `pe_exec` is high for exactly one cycle, 5 cycles after the fetch request. `pe_arg` then holds operand bits [9:0] zero-extended to 32 bits.
- R4: A binary instruction (opcode bit 8 = 0) with operand bit 21 = 1 reads memory at operand bits [9:0] three cycles after its fetch request. Execution moves to 6 cycles after the fetch request, and `pe_arg` holds the word that was read.
- R5: A unary instruction (opcode bit 8 = 1) ignores operand bit 21. It performs no operand read and uses the immediate timing and value of R3.
- R6: When opcode bit 9 = 1, `pe_wb` is high in the cycle after `pe_exec`, and the next fetch starts one cycle later.
- R7: All lanes of `pe_exec` and `pe_wb` are asserted together in the same cycle.
- R8: Opcode 3 stores the buffer word of the lane selected by operand bits [11:10] to address operand bits [9:0]. `mem_wr` is high 3 and 4 cycles after the execute slot, with the data stable. The next fetch follows in the cycle after. No lane is strobed.
- R9: Opcode 2 loads operand bits [9:0] into the program counter. The next fetch starts in the cycle after the execute slot, and no lane is strobed.
- R10: Opcode 1 raises `done` in the cycle after the execute slot. `done` stays high until reset, with no further memory access and no lane strobe.
- R11: Opcode 0 and every opcode outside 1 to 3 strobe the lanes. Each instruction starts its fetch only in the cycle after the previous one ends.
- R12: While reset is held, `done`, `pe_exec`, `pe_wb` and `mem_wr` are low, and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 10 | Memory word address |
| mem_rd | output | 1 | Read request; data returns in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, held until the next read |
| pe_exec | output | NUM_PE | Execute strobe per lane |
| pe_wb | output | NUM_PE | Result-to-register copy strobe per lane |
| pe_op | output | 10 | Broadcast operation field |
| pe_opnd | output | 22 | Broadcast raw operand field |
| pe_arg | output | 32 | Broadcast resolved second operand |
| pe_buf | input | 32*NUM_PE | Buffer word of each lane |
| done | output | 1 | Sequencer halted |

## Verification
Take the cycle in which an instruction's fetch request appears as t. Execution is due at t+5, or at t+6 with a memory operand. Write-back is due one cycle after execution. Store writes fall 3 and 4 cycles after execution, and `done` rises one cycle after a halt's execute slot. The bench walks its own model of the program to produce a list of every read, execute, write-back and write event, stamped with the exact cycle since reset release. Outputs are sampled on the falling edge, and each event is compared with the next expected entry, so an early, late, missing or extra event is reported.

// File: rtl/simd_seq.sv
module simd_seq #(
  parameter int NUM_PE = 4,
  parameter int AW     = 10,
  parameter int DW     = 32,
  parameter int OPW    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  output logic [NUM_PE-1:0]    pe_exec,
  output logic [NUM_PE-1:0]    pe_wb,
  output logic [OPW-1:0]       pe_op,
  output logic [DW-OPW-1:0]    pe_opnd,
  output logic [DW-1:0]        pe_arg,
  input  logic [NUM_PE*DW-1:0] pe_buf,
  output logic                 done
);
  localparam int ODW = DW - OPW;
  localparam int LSW = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_D1, S_D2, S_MW, S_D3, S_EX, S_WB,
    S_S1, S_S2, S_S3, S_S4, S_HLT
  } phase_t;

  phase_t         st;
  logic [AW-1:0]  pc;
  logic [DW-1:0]  ir, arg, sbuf;

  logic [OPW-1:0] op;
  logic [ODW-1:0] opd;
  logic           ctl, is_halt, is_jump, is_store, mem_mode;
  logic [LSW-1:0] lane;
  logic [DW-1:0]  imm;

  assign op       = ir[DW-1 -: OPW];
  assign opd      = ir[ODW-1:0];
  assign ctl      = (op[OPW-1:2] == '0) && (op[1:0] != 2'd0);
  assign is_halt  = ctl && (op[1:0] == 2'd1);
  assign is_jump  = ctl && (op[1:0] == 2'd2);
  assign is_store = ctl && (op[1:0] == 2'd3);
  assign mem_mode = opd[ODW-1] && !op[OPW-2] && !ctl;
  assign lane     = opd[AW +: LSW];
  assign imm      = {{(DW-AW){1'b0}}, opd[AW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_F1;
      pc   <= '0;
      ir   <= '0;
      arg  <= '0;
      sbuf <= '0;
    end else begin
      case (st)
        S_F1: st <= S_F2;
        S_F2: begin
          pc <= pc + AW'(1);
          st <= S_D1;
        end
        S_D1: begin
          ir <= mem_rdata;
          st <= S_D2;
        end
        S_D2: st <= mem_mode ? S_MW : S_D3;
        S_MW: st <= S_D3;
        S_D3: begin
          arg <= mem_mode ? mem_rdata : imm;
          st  <= S_EX;
        end
        S_EX: begin
          if (is_halt)        st <= S_HLT;
          else if (is_jump) begin
            pc <= opd[AW-1:0];
            st <= S_F1;
          end
          else if (is_store)  st <= S_S1;
          else if (op[OPW-1]) st <= S_WB;
          else                st <= S_F1;
        end
        S_WB: st <= S_F1;
        S_S1: begin
          sbuf <= pe_buf[lane*DW +: DW];
          st   <= S_S2;
        end
        S_S2: st <= S_S3;
        S_S3: st <= S_S4;
        S_S4: st <= S_F1;
        S_HLT: st <= S_HLT;
        default: st <= S_F1;
      endcase
    end
  end

  assign mem_rd    = (st == S_F1) || ((st == S_D2) && mem_mode);
  assign mem_wr    = (st == S_S3) || (st == S_S4);
  assign mem_addr  = (st == S_F1 || st == S_F2) ? pc : opd[AW-1:0];
  assign mem_wdata = sbuf;
  assign pe_exec   = {NUM_PE{(st == S_EX) && !ctl}};
  assign pe_wb     = {NUM_PE{st == S_WB}};
  assign pe_op     = op;
  assign pe_opnd   = opd;
  assign pe_arg    = arg;
  assign done      = (st == S_HLT);
endmodule

// File: rtl/simd_seq_chk.sv
module simd_seq_chk #(
  parameter int NUM_PE = 4,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DW-1:0]     mem_wdata,
  input logic [NUM_PE-1:0] pe_exec,
  input logic [NUM_PE-1:0] pe_wb,
  input logic              done
);
  a_r7_exec_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_exec == '0) || (pe_exec == '1));

  a_r7_wb_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_wb == '0) || (pe_wb == '1));

  a_r6_wb_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (|pe_wb) |-> $past(|pe_exec));

  a_r8_wdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $stable(mem_wdata));

  a_r10_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r10_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !mem_wr && pe_exec == '0 && pe_wb == '0));

  a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind simd_seq simd_seq_chk #(.NUM_PE(NUM_PE), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .pe_exec(pe_exec), .pe_wb(pe_wb), .done(done)
);

// File: tb/test_simd_seq.sv
module test_simd_seq;
  localparam int NPE = 4;
  localparam logic [31:0] HALT_W = {10'd1, 22'd0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [9:0]       mem_addr;
  logic             mem_rd, mem_wr, done;
  logic [31:0]      mem_wdata, mem_rdata, pe_arg;
  logic [NPE-1:0]   pe_exec, pe_wb;
  logic [9:0]       pe_op;
  logic [21:0]      pe_opnd;
  logic [NPE*32-1:0] pe_buf;

  simd_seq #(.NUM_PE(NPE)) i_simd_seq (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pe_exec(pe_exec), .pe_wb(pe_wb), .pe_op(pe_op), .pe_opnd(pe_opnd),
    .pe_arg(pe_arg), .pe_buf(pe_buf), .done(done)
  );

  logic [31:0] mem  [1024];
  logic [31:0] emem [1024];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit running = 0;

  int x_n, xi, x_cyc[256]; logic [9:0] x_op[256]; logic [31:0] x_arg[256]; string x_tag[256];
  int w_n, wi, w_cyc[256]; logic [21:0] w_opd[256];
  int s_n, si, s_cyc[256]; logic [9:0] s_addr[256]; logic [31:0] s_dat[256];
  int r_n, ri, r_cyc[256]; logic [9:0] r_addr[256]; string r_tag[256];
  int done_cyc;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] ins(input logic [9:0] op, input logic [21:0] o);
    return {op, o};
  endfunction

  task automatic add_rd(input int c, input logic [9:0] a, input string tag);
    r_cyc[r_n] = c; r_addr[r_n] = a; r_tag[r_n] = tag; r_n++;
  endtask

  // Reference walk over the program: builds every event with its due cycle
  task automatic build();
    int t, pc, ex;
    logic [31:0] w, d;
    logic [9:0] op;
    logic [21:0] o;
    bit ctl, mm;
    t = 0; pc = 0; x_n = 0; w_n = 0; s_n = 0; r_n = 0; done_cyc = -1;
    for (int k = 0; k < 200 && done_cyc < 0; k++) begin
      w = emem[pc]; op = w[31:22]; o = w[21:0];
      ctl = (op[9:2] == 0) && (op[1:0] != 0);
      mm  = o[21] && !op[8] && !ctl;
      ex  = t + 5 + int'(mm);
      add_rd(t, pc[9:0], "R2");
      if (mm) add_rd(t + 3, o[9:0], "R4");
      pc = (pc + 1) % 1024;
      if (ctl && op[1:0] == 2'd1) done_cyc = ex + 1;
      else if (ctl && op[1:0] == 2'd2) begin pc = int'(o[9:0]); t = ex + 1; end
      else if (ctl) begin
        d = pe_buf[o[11:10]*32 +: 32];
        for (int j = 3; j <= 4; j++) begin
          s_cyc[s_n] = ex + j; s_addr[s_n] = o[9:0]; s_dat[s_n] = d; s_n++;
        end
        emem[o[9:0]] = d;
        t = ex + 5;
      end else begin
        x_cyc[x_n] = ex; x_op[x_n] = op;
        x_arg[x_n] = mm ? emem[o[9:0]] : {22'd0, o[9:0]};
        x_tag[x_n] = mm ? "R4" : (op[8] ? "R5" : "R3");
        x_n++;
        if (op[9]) begin w_cyc[w_n] = ex + 1; w_opd[w_n] = o; w_n++; t = ex + 2; end
        else t = ex + 1;
      end
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (pe_exec != '0) begin
        chk(pe_exec == '1, "R7", 64'(pe_exec), 64'({NPE{1'b1}}));
        if (xi < x_n) begin
          chk(cyc == x_cyc[xi] && pe_op == x_op[xi] && pe_arg == x_arg[xi], x_tag[xi],
              {16'(cyc), 6'd0, pe_op, pe_arg}, {16'(x_cyc[xi]), 6'd0, x_op[xi], x_arg[xi]});
          xi++;
        end else chk(0, "R11 extra exec", 64'(cyc), 64'(0));
      end
      if (pe_wb != '0) begin
        chk(pe_wb == '1, "R7", 64'(pe_wb), 64'({NPE{1'b1}}));
        if (wi < w_n) begin
          chk(cyc == w_cyc[wi] && pe_opnd == w_opd[wi], "R6 R1",
              {16'(cyc), 26'd0, pe_opnd}, {16'(w_cyc[wi]), 26'd0, w_opd[wi]});
          wi++;
        end else chk(0, "R6 extra write-back", 64'(cyc), 64'(0));
      end
      if (mem_wr) begin
        if (si < s_n) begin
          chk(cyc == s_cyc[si] && mem_addr == s_addr[si] && mem_wdata == s_dat[si], "R8",
              {16'(cyc), 6'd0, mem_addr, mem_wdata}, {16'(s_cyc[si]), 6'd0, s_addr[si], s_dat[si]});
          si++;
        end else chk(0, "R8 extra write", 64'(cyc), 64'(0));
      end
      if (mem_rd) begin
        if (ri < r_n) begin
          chk(cyc == r_cyc[ri] && mem_addr == r_addr[ri], r_tag[ri],
              {16'(cyc), 38'd0, mem_addr}, {16'(r_cyc[ri]), 38'd0, r_addr[ri]});
          ri++;
        end else chk(0, "R10 R11 extra read", 64'(cyc), 64'(0));
      end
      if (cyc == done_cyc || done != (done_cyc >= 0 && cyc >= done_cyc))
        chk(done == (done_cyc >= 0 && cyc >= done_cyc), "R10", 64'(done), 64'(cyc >= done_cyc));
      cyc++;
    end
  end

  task automatic run();
    int lim;
    for (int k = 0; k < 1024; k++) emem[k] = mem[k];
    build();
    xi = 0; wi = 0; si = 0; ri = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: idle outputs while reset is held
    chk(!done && pe_exec == '0 && pe_wb == '0 && !mem_wr && mem_addr == '0, "R12",
        {done, 3'd0, pe_exec, pe_wb, mem_wr, mem_addr}, 64'(0));
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    cyc = 0;
    running = 1;
    lim = (done_cyc >= 0) ? done_cyc + 12 : 3000;
    while (cyc < lim) @(negedge clk);
    @(posedge clk);
    running = 0;
    chk(xi == x_n, "R3 missing exec", 64'(xi), 64'(x_n));
    chk(wi == w_n, "R6 missing write-back", 64'(wi), 64'(w_n));
    chk(si == s_n, "R8 missing write", 64'(si), 64'(s_n));
    chk(ri == r_n, "R2 missing read", 64'(ri), 64'(r_n));
    chk(done == 1'b1, "R10 halted", 64'(done), 64'(1));
  endtask

  task automatic clear();
    for (int k = 0; k < 1024; k++) mem[k] = 32'd0;
    pe_buf = {32'hA0A0_0003, 32'hB1B1_0002, 32'hC2C2_0001, 32'hD3D3_0000};
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd97531));
    // R1 R3: immediate operation
    clear();
    mem[0] = ins(10'h004, 22'h0002A);
    mem[1] = HALT_W;
    run();
    // R4 R5 R6: memory operand, unary ignoring mode bit, write-back
    clear();
    mem[0] = ins(10'h005, {1'b1, 11'd0, 10'd700});
    mem[1] = ins(10'h140, {1'b1, 11'd0, 10'd701});
    mem[2] = ins(10'h204, 22'h00015);
    mem[3] = ins(10'h000, 22'h003FF);
    mem[4] = HALT_W;
    mem[700] = 32'hDEAD_BEEF;
    mem[701] = 32'h1234_5678;
    run();
    // R9: jump skips the next word
    clear();
    mem[0]  = ins(10'd2, 22'd10);
    mem[1]  = ins(10'h004, 22'd1);
    mem[10] = ins(10'h008, 22'd5);
    mem[11] = HALT_W;
    run();
    // R8: store lane 2 then read it back as a memory operand
    clear();
    mem[0] = ins(10'd3, {10'd0, 2'd2, 10'd600});
    mem[1] = ins(10'h005, {1'b1, 11'd0, 10'd600});
    mem[2] = HALT_W;
    run();
    // R2: counter wrap; a store rewrites word 0 into a halt
    clear();
    pe_buf[63:32] = HALT_W;
    mem[0]    = ins(10'd2, 22'd1023);
    mem[1023] = ins(10'd3, {10'd0, 2'd1, 10'd0});
    run();
    // Random programs
    for (int r = 0; r < 20; r++) begin
      for (int k = 0; k < 1024; k++) mem[k] = $urandom;
      for (int k = 0; k < 12; k++) begin
        logic [9:0] op;
        logic [21:0] o;
        int c;
        c = int'($urandom % 6);
        op = 10'($urandom);
        o = 22'($urandom);
        o[9] = 1'b1;
        if (c == 4) op = 10'd3;
        else if (c == 5) op = 10'd0;
        else if (op[9:2] == 8'd0) op[2] = 1'b1;
        mem[k] = {op, o};
      end
      mem[12] = HALT_W;
      pe_buf = {$urandom, $urandom, $urandom, $urandom};
      run();
    end
    report();
  end
endmodule